// File: doc/BRIEF.md
# Presettable Synchronous Decade/Binary Up-Counter

This block is a 4-bit synchronous up-counter. A build-time parameter selects one of two count lengths. Decade mode counts 0 to 9 in 8421 BCD. Binary mode counts 0 to 15.

An active-low clear acts at once and is independent of the clock. An active-low load takes a 4-bit word on the next rising edge. Counting takes two enables, and both must be high. One of them, the trickle enable, also gates the terminal-count flag. Stages can therefore be chained: either ripple the flag into the next stage's trickle enable, or fan one stage's flag out to the parallel enables of all the others.

In decade mode the six unused codes cannot trap the counter. Each one falls back into the 0 to 9 loop within two counts.

Top module: `sync_preset_counter`

## Requirements
- R1: With DECADE=1 and counting enabled, q steps 0,1,...,9 and then goes from 9 to 0 on the next rising edge.
- R2: With DECADE=0 and counting enabled, q steps 0 to 15 and then goes from 15 to 0 on the next rising edge.
- R3: While clr_n is low, q is 0 without waiting for a clock edge. This holds whatever load_n, din and the enables are doing. Clear has the highest precedence.
- R4: When clr_n is high and load_n is low, the next rising edge copies din into q, and the enable inputs have no effect.
- R5: When clr_n and load_n are high, q advances on a rising edge only if en_par and en_trk are both 1. If either is 0, q keeps its value.
- R6: tc is 1 exactly when en_trk is 1 and q is at the top count (9 when DECADE=1, 15 when DECADE=0). en_par has no effect on tc. tc follows its inputs without a clock.
- R7: With DECADE=1 and counting enabled, the unused codes move as follows: 10→11, 11→6, 12→13, 13→4, 14→15 and 15→2. tc is 0 in every one of them.
- R8: Any 4-bit din value can be loaded, including 10 to 15 when DECADE=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every change except clear happens on its rising edge |
| clr_n | input | 1 | Active-low clear; immediate, overrides everything |
| load_n | input | 1 | Active-low synchronous parallel load |
| din | input | 4 | Parallel load value |
| en_par | input | 1 | Parallel count enable; does not affect tc |
| en_trk | input | 1 | Trickle count enable; also gates tc |
| q | output | 4 | Counter state |
| tc | output | 1 | Terminal count flag |

## Verification
Load, count and hold results appear on q one rising edge after the inputs that cause them. The bench therefore sets inputs on a falling edge and reads q on the following falling edge, half a period after the edge that updates it.

Clear and tc need no clock. The bench checks them a nanosecond after changing the inputs, before any rising edge.

A decade instance and a binary instance run side by side on the same inputs. The bench loads every 4-bit code and follows it for two counts. Each expected value comes from modular arithmetic in the bench.

// File: rtl/cnt_pkg.sv
// Package: types shared by the counter blocks.
// Assumes a fixed 4-bit state; the count length is chosen by DECADE.
package cnt_pkg;
    localparam int CNT_W = 4;

    // Synchronous operating mode after the clear has been ruled out.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_LOAD  = 2'd2
    } cnt_mode_e;
endpackage

// File: rtl/cnt_mode_sel.sv
// Module: cnt_mode_sel
// Ranks the synchronous controls into a single mode.
// Load beats count, and count beats hold.
// Assumes the clear is handled outside this block, at the register.
module cnt_mode_sel
    import cnt_pkg::*;
(
    input  logic      load_n,
    input  logic      en_par,
    input  logic      en_trk,
    output cnt_mode_e mode
);
    // Purpose: apply the fixed precedence load > count > hold.
    always_comb begin
        if (!load_n)
            mode = MODE_LOAD;
        else if (en_par && en_trk)
            mode = MODE_COUNT;
        else
            mode = MODE_HOLD;
    end
endmodule

// File: rtl/cnt_next.sv
// Module: cnt_next
// Works out the next counter state for the selected mode.
// DECADE=1 gives the BCD loop, with fixed exits from the six unused codes.
// DECADE=0 gives a plain binary wrap.
// Assumes CNT_W is 4.
module cnt_next
    import cnt_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic [CNT_W-1:0] cur,
    input  logic [CNT_W-1:0] din,
    input  cnt_mode_e        mode,
    output logic [CNT_W-1:0] nxt
);
    logic [CNT_W-1:0] inc;

    generate
        if (DECADE) begin : g_dec
            // Purpose: BCD increment plus the recovery path from unused codes.
            always_comb begin
                case (cur)
                    4'd9:    inc = 4'd0;
                    4'd10:   inc = 4'd11;
                    4'd11:   inc = 4'd6;
                    4'd12:   inc = 4'd13;
                    4'd13:   inc = 4'd4;
                    4'd14:   inc = 4'd15;
                    4'd15:   inc = 4'd2;
                    default: inc = cur + 4'd1;
                endcase
            end
        end else begin : g_bin
            // Purpose: binary increment that wraps naturally at 15.
            always_comb inc = cur + 4'd1;
        end
    endgenerate

    // Purpose: choose load, increment or hold.
    always_comb begin
        unique case (mode)
            MODE_LOAD:  nxt = din;
            MODE_COUNT: nxt = inc;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/cnt_tc_decode.sv
// Module: cnt_tc_decode
// Terminal-count flag: fully decodes the top state and ANDs it with en_trk.
// It is combinational, so it may glitch; use it as an enable, not as a clock.
module cnt_tc_decode
    import cnt_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic [CNT_W-1:0] cur,
    input  logic             en_trk,
    output logic             tc
);
    localparam logic [CNT_W-1:0] TOP = DECADE ? 4'd9 : 4'd15;

    // Purpose: full decode of the top count, gated by the trickle enable.
    always_comb tc = en_trk && (cur == TOP);
endmodule

// File: rtl/sync_preset_counter.sv
// Module: sync_preset_counter (top)
// A presettable 4-bit up-counter, decade or binary according to DECADE.
// clr_n clears the state at once, without the clock. Load, count and hold
// act on the rising edge of clk.
// Assumes din and the enables are steady around the rising edge.
module sync_preset_counter
    import cnt_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [CNT_W-1:0] din,
    input  logic             en_par,
    input  logic             en_trk,
    output logic [CNT_W-1:0] q,
    output logic             tc
);
    cnt_mode_e        mode;
    logic [CNT_W-1:0] state_q;
    logic [CNT_W-1:0] state_d;

    cnt_mode_sel u_mode (
        .load_n (load_n),
        .en_par (en_par),
        .en_trk (en_trk),
        .mode   (mode)
    );

    cnt_next #(.DECADE(DECADE)) u_next (
        .cur  (state_q),
        .din  (din),
        .mode (mode),
        .nxt  (state_d)
    );

    // Purpose: state register with the immediate active-low clear.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    cnt_tc_decode #(.DECADE(DECADE)) u_tc (
        .cur    (state_q),
        .en_trk (en_trk),
        .tc     (tc)
    );

    assign q = state_q;
endmodule

// File: rtl/sync_preset_counter_chk.sv
// Module: sync_preset_counter_chk
// Property checker, bound onto every sync_preset_counter instance.
module sync_preset_counter_chk #(
    parameter bit DECADE = 1'b1
) (
    input logic       clk,
    input logic       clr_n,
    input logic       load_n,
    input logic [3:0] din,
    input logic       en_par,
    input logic       en_trk,
    input logic [3:0] q,
    input logic       tc
);
    localparam logic [3:0] TOP = DECADE ? 4'd9 : 4'd15;

    // R3
    clear_zero_chk: assert property (@(posedge clk) !clr_n |-> (q == 4'd0));

    // R4
    load_copy_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (q == $past(din)));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_par && en_trk)) |=> $stable(q));

    // R1
    top_wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trk && q == TOP) |=> (q == 4'd0));

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trk && q < TOP) |=> (q == $past(q) + 4'd1));

    // R6
    tc_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
        tc |-> (en_trk && q == TOP));

    // R7
    odd_spare_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (DECADE && load_n && en_par && en_trk && q > 4'd9 && q[0]) |=> (q <= 4'd9));

    // R7
    spare_tc_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (q > 4'd9 && DECADE) |-> !tc);
endmodule

bind sync_preset_counter sync_preset_counter_chk #(.DECADE(DECADE)) u_chk (
    .clk    (clk),
    .clr_n  (clr_n),
    .load_n (load_n),
    .din    (din),
    .en_par (en_par),
    .en_trk (en_trk),
    .q      (q),
    .tc     (tc)
);

// File: tb/tb_sync_preset_counter.sv
// Bench: a decade and a binary instance run on shared inputs and are
// compared against arithmetic expected values.
module tb_sync_preset_counter;
    logic       clk = 1'b0;
    logic       clr_n;
    logic       load_n;
    logic [3:0] din;
    logic       en_par;
    logic       en_trk;
    logic [3:0] q_d, q_b;
    logic       tc_d, tc_b;
    int         total = 0;
    int         bad   = 0;
    logic [3:0] exp_d, exp_b;

    always #10 clk = ~clk;

    sync_preset_counter #(.DECADE(1'b1)) dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_par(en_par), .en_trk(en_trk), .q(q_d), .tc(tc_d));

    sync_preset_counter #(.DECADE(1'b0)) dut_b (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_par(en_par), .en_trk(en_trk), .q(q_b), .tc(tc_b));

    // Expected next state, worked out arithmetically.
    function automatic logic [3:0] model(input logic [3:0] cur, input bit dec);
        int v;
        v = int'(cur);
        if (!load_n) return din;
        if (!(en_par && en_trk)) return cur;
        if (!dec) return 4'((v + 1) % 16);
        if (v <= 9) return 4'((v + 1) % 10);
        if (v % 2 == 1) return 4'(17 - v);
        return 4'(v + 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_tc(input string req);
        chk(req, int'(tc_d), int'(en_trk && exp_d == 4'd9));
        chk(req, int'(tc_b), int'(en_trk && exp_b == 4'd15));
    endtask

    // One clock: predict, let the edge pass, then read on the falling edge.
    task automatic tick(input string req);
        exp_d = model(exp_d, 1'b1);
        exp_b = model(exp_b, 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk(req, int'(q_d), int'(exp_d));
        chk(req, int'(q_b), int'(exp_b));
    endtask

    task automatic set_in(input logic ld, input logic [3:0] d, input logic ep, input logic et);
        load_n = ld; din = d; en_par = ep; en_trk = et;
    endtask

    initial begin
        #(200000 * 20);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clr_n = 1'b0;
        set_in(1'b0, 4'd7, 1'b1, 1'b1);
        exp_d = 4'd0; exp_b = 4'd0;
        repeat (2) @(negedge clk);
        // R3: reset state while the load is held active.
        chk("R3", int'(q_d), 0);
        chk("R3", int'(q_b), 0);
        clr_n = 1'b1;

        // R4: load overrides the count enables.
        set_in(1'b0, 4'd3, 1'b1, 1'b1);
        tick("R4");
        set_in(1'b0, 4'd0, 1'b1, 1'b1);
        tick("R4");

        // R1, R2, R6: free-running sweep past both wraps.
        set_in(1'b1, 4'd0, 1'b1, 1'b1);
        for (int i = 0; i < 34; i++) begin
            tick("R1/R2 sweep");
            chk_tc("R6");
        end

        // R5 and R6: hold with each enable combination, at the decade top.
        set_in(1'b0, 4'd9, 1'b1, 1'b1);
        tick("R4");
        for (int c = 0; c < 3; c++) begin
            set_in(1'b1, 4'd0, c[0], c[1]);
            #1 chk_tc("R6 en_par ignored");
            tick("R5 hold");
        end

        // R7, R8: load every code, then count twice.
        for (int v = 0; v < 16; v++) begin
            set_in(1'b0, 4'(v), 1'b1, 1'b1);
            tick("R8 load");
            chk_tc("R7 tc");
            set_in(1'b1, 4'd0, 1'b1, 1'b1);
            tick("R7 step1");
            chk_tc("R7 tc");
            tick("R7 step2");
            if (v > 9) chk("R7 recovered", int'(q_d <= 4'd9), 1);
        end

        // R3: clear mid-cycle, with load and count both requested.
        set_in(1'b0, 4'd5, 1'b1, 1'b1);
        tick("R4");
        #5 clr_n = 1'b0;
        #1 chk("R3 async", int'(q_d), 0);
        chk("R3 async", int'(q_b), 0);
        exp_d = 4'd0; exp_b = 4'd0;
        @(posedge clk);
        @(negedge clk);
        chk("R3 held", int'(q_d), 0);
        clr_n = 1'b1;
        set_in(1'b1, 4'd0, 1'b1, 1'b1);
        tick("R1 after clear");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule